// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog peripheral on a simple APB-style register bus with 32-bit data and byte offsets. Software enables it and picks two power-of-two timeout codes. The first countdown after enabling uses the start code. Every later countdown uses the range code. Software keeps the system alive by writing a fixed key to the kick register before the count reaches zero.

When the count expires, the block responds in one of two ways, chosen by a mode bit. In immediate mode it pulses a system reset request for one cycle. In interrupt-first mode the first expiry raises an interrupt and restarts the count. If a second expiry arrives while that interrupt is still pending, the block pulses the reset request. Reading the acknowledge offset clears the pending interrupt.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, every mapped offset reads 0 and both `irq_o` and `sys_rst_req_o` are 0.
- R2: The control register at 0x00 reads back mode in bit 1 and enable in bit 0. The range register at 0x04 reads back the start code in bits [7:4] and the range code in bits [3:0]. All other bits read 0. The kick offset 0x0C reads 0. Offsets that are not mapped read 0, and writes to them are ignored.
- R3: A write of 1 to control bit 0 while the block is disabled loads the counter. `sys_rst_req_o` (mode 0) then pulses exactly 2^(BASE_EXP+s) cycles after the write edge, where s is the start code.
- R4: While enabled, writing exactly 32'h0000_0076 to offset 0x0C reloads the counter. The next expiry then comes 2^(BASE_EXP+r) cycles after that write edge, where r is the range code.
- R5: A write of any other value to 0x0C leaves the expiry time unchanged.
- R6: In mode 0, each expiry gives a one-cycle `sys_rst_req_o` pulse and reloads the counter from the range code. Consecutive pulses are therefore 2^(BASE_EXP+r) cycles apart.
- R7: In mode 1, an expiry with no pending interrupt sets `irq_o` without a reset request. An expiry while the interrupt is pending pulses `sys_rst_req_o`.
- R8: Offset 0x10 reads the pending interrupt in bit 0. A read of 0x14 returns the same bit and clears the pending interrupt, so the next expiry raises an interrupt again instead of a reset.
- R9: Writing control bit 0 as 0 stops the counter: no interrupt or reset request follows, and key writes are ignored. Enabling again restarts from the start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 8 | Byte offset |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid while selected for a read |
| irq_o | output | 1 | Pending interrupt, level |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench measures the exact cycle of every expiry against the write edge that caused it. An off-by-one in the load value, or a first countdown that uses the range code instead of the start code, shows up as a wrong cycle count. It checks that near-miss key values do not restart the count, and that a key write while stopped does not revive the block; a decoder that checks too few bits would shorten or wake the timeout. In interrupt-first mode it checks the irq-then-reset order, and that an acknowledge re-arms the interrupt. A design that lost the pending state, or failed to clear it on read, would reset too early or too late.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0]  OFS_CTRL  = 8'h00;
  localparam logic [7:0]  OFS_RANGE = 8'h04;
  localparam logic [7:0]  OFS_KICK  = 8'h0C;
  localparam logic [7:0]  OFS_STAT  = 8'h10;
  localparam logic [7:0]  OFS_ACK   = 8'h14;
  localparam logic [31:0] KICK_KEY  = 32'h0000_0076;
  localparam int          CODE_W    = 4;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [7:0]        paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  input  logic              irq_i,
  output logic              en_o,
  output logic              mode_o,
  output logic [CODE_W-1:0] init_code_o,
  output logic [CODE_W-1:0] range_code_o,
  output logic              start_o,
  output logic              kick_o,
  output logic              ack_o
);
  logic wr_acc, rd_acc;
  logic en_q, mode_q;
  logic [CODE_W-1:0] init_q, range_q;

  assign wr_acc = psel_i && penable_i && pwrite_i;
  assign rd_acc = psel_i && penable_i && !pwrite_i;

  assign start_o = wr_acc && (paddr_i == OFS_CTRL) && pwdata_i[0] && !en_q;
  assign kick_o  = wr_acc && (paddr_i == OFS_KICK) && (pwdata_i == KICK_KEY) && en_q;
  assign ack_o   = rd_acc && (paddr_i == OFS_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      init_q  <= '0;
      range_q <= '0;
    end else if (wr_acc) begin
      if (paddr_i == OFS_CTRL) begin
        en_q   <= pwdata_i[0];
        mode_q <= pwdata_i[1];
      end
      if (paddr_i == OFS_RANGE) begin
        range_q <= pwdata_i[CODE_W-1:0];
        init_q  <= pwdata_i[2*CODE_W-1:CODE_W];
      end
    end
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      case (paddr_i)
        OFS_CTRL:         prdata_o[1:0] = {mode_q, en_q};
        OFS_RANGE:        prdata_o[2*CODE_W-1:0] = {init_q, range_q};
        OFS_STAT, OFS_ACK: prdata_o[0] = irq_i;
        default:          prdata_o = '0;
      endcase
    end
  end

  assign en_o         = en_q;
  assign mode_o       = mode_q;
  assign init_code_o  = init_q;
  assign range_code_o = range_q;

  assert_start_enables_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> en_o);
  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !pwrite_i && paddr_i == 8'h08) |-> prdata_o == 32'd0);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              kick_i,
  input  logic [CODE_W-1:0] init_code_i,
  input  logic [CODE_W-1:0] range_code_i,
  output logic              expire_o
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] load_val(input logic [CODE_W-1:0] code);
    return {CNT_W{1'b1}} >> (CNT_W - BASE_EXP - int'(code));
  endfunction

  assign expire_o = en_i && !start_i && !kick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (start_i)    cnt_q <= load_val(init_code_i);
    else if (!en_i)      cnt_q <= cnt_q;
    else if (kick_i || cnt_q == '0) cnt_q <= load_val(range_code_i);
    else                 cnt_q <= cnt_q - 1'b1;
  end

  initial begin
    assert_fit_R3: assert (BASE_EXP >= 1 && BASE_EXP + MAX_CODE <= CNT_W);
  end

  assert_expire_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  assert_hold_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic mode_i,
  input  logic ack_i,
  output logic irq_o,
  output logic rst_req_o
);
  logic irq_q, rst_q, irq_set;

  assign irq_set = expire_i && mode_i && !irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      // second expiry with irq still pending escalates to reset
      rst_q <= expire_i && (!mode_i || irq_q);
      irq_q <= irq_set || (irq_q && !ack_i);
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  assert_irq_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && mode_i && !irq_o) |=> (irq_o && !rst_req_o));
  assert_escalate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && mode_i && irq_o) |=> rst_req_o);
  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !expire_i) |=> !irq_o);
  assert_mode0_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !mode_i) |=> rst_req_o);
  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        psel_i,
  input  logic        penable_i,
  input  logic        pwrite_i,
  input  logic [7:0]  paddr_i,
  input  logic [31:0] pwdata_i,
  output logic [31:0] prdata_o,
  output logic        irq_o,
  output logic        sys_rst_req_o
);
  logic              en, mode, start, kick, ack, expire, irq;
  logic [CODE_W-1:0] init_code, range_code;

  wdog_regs i_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .prdata_o,
    .irq_i        (irq),
    .en_o         (en),
    .mode_o       (mode),
    .init_code_o  (init_code),
    .range_code_o (range_code),
    .start_o      (start),
    .kick_o       (kick),
    .ack_o        (ack)
  );

  wdog_counter #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) i_counter (
    .clk_i, .rst_ni,
    .en_i         (en),
    .start_i      (start),
    .kick_i       (kick),
    .init_code_i  (init_code),
    .range_code_i (range_code),
    .expire_o     (expire)
  );

  wdog_resp i_resp (
    .clk_i, .rst_ni,
    .expire_i  (expire),
    .mode_i    (mode),
    .ack_i     (ack),
    .irq_o     (irq),
    .rst_req_o (sys_rst_req_o)
  );

  assign irq_o = irq;

  assert_quiet_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !start && !sys_rst_req_o) |=> !sys_rst_req_o);
endmodule

// File: tb/test_wdog_keyed.sv
`timescale 1ns/1ps
module test_wdog_keyed;
  localparam int BE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic irq, rst_req;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  wdog_keyed #(.CNT_W(32), .BASE_EXP(BE)) i_wdog_keyed (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .irq_o(irq), .sys_rst_req_o(rst_req));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int tmo(int code);
    return 1 << (BE + code);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d, output int at);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(posedge clk); #1 at = cyc;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_evt(int limit, output int at, output bit is_rst);
    bit irq0 = irq;
    bit hit = 0;
    int n = 0;
    at = -1; is_rst = 0;
    while (!hit && n < limit) begin
      @(posedge clk); #1; n++;
      if (rst_req) begin at = cyc; is_rst = 1; hit = 1; end
      else if (irq && !irq0) begin at = cyc; hit = 1; end
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all R): actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int w, at, prev;
    bit isr;
    void'($urandom(32'h5EED_0042));

    // R1 reset state
    #12 rst_n = 1;
    idle(2);
    chk(irq == 0 && rst_req == 0, "R1 outputs", {irq, rst_req}, 0);
    bus_rd(8'h00, d); chk(d == 0, "R1 ctrl", d, 0);
    bus_rd(8'h04, d); chk(d == 0, "R1 range", d, 0);
    bus_rd(8'h10, d); chk(d == 0, "R1 status", d, 0);

    // R2 readback and unmapped
    bus_wr(8'h00, 32'hFFFF_FFFE, w); bus_rd(8'h00, d); chk(d == 2, "R2 ctrl", d, 2);
    bus_wr(8'h04, 32'hFFFF_FFAB, w); bus_rd(8'h04, d); chk(d == 32'hAB, "R2 range", d, 32'hAB);
    bus_rd(8'h0C, d); chk(d == 0, "R2 kick reads 0", d, 0);
    bus_wr(8'h08, 32'hFFFF_FFFF, w); bus_rd(8'h08, d); chk(d == 0, "R2 unmapped 08", d, 0);
    bus_wr(8'h20, 32'hFFFF_FFFF, w); bus_rd(8'h20, d); chk(d == 0, "R2 unmapped 20", d, 0);
    bus_rd(8'h00, d); chk(d == 2, "R2 ctrl untouched", d, 2);
    bus_wr(8'h00, 32'h0, w);
    idle(50);
    chk(rst_req == 0 && irq == 0, "R9 idle while off", {irq, rst_req}, 0);

    // random mode-0 rounds
    for (int it = 0; it < 12; it++) begin
      int ic = $urandom % 4;
      int rc = $urandom % 4;
      bus_wr(8'h04, {24'h0, 4'(ic), 4'(rc)}, w);
      bus_wr(8'h00, 32'h1, w);
      wait_evt(tmo(3) + 8, at, isr);
      chk(isr && at == w + tmo(ic), "R3 first expiry", at - w, tmo(ic));
      idle(1);
      chk(rst_req == 0, "R6 one-cycle pulse", rst_req, 0);
      prev = at;
      wait_evt(tmo(3) + 8, at, isr);
      chk(isr && at == prev + tmo(rc), "R6 period", at - prev, tmo(rc));
      prev = at;
      if (it % 2 == 1) begin
        idle($urandom % 4);
        bus_wr(8'h0C, 32'h76, w);
        wait_evt(tmo(3) + 8, at, isr);
        chk(isr && at == w + tmo(rc), "R4 key reload", at - w, tmo(rc));
      end else begin
        logic [31:0] v = $urandom;
        if (v == 32'h76) v = 32'h176;
        bus_wr(8'h0C, v, w);
        wait_evt(tmo(3) + 8, at, isr);
        chk(isr && at == prev + tmo(rc), "R5 non-key ignored", at - prev, tmo(rc));
      end
      bus_wr(8'h00, 32'h0, w);
      if (it % 4 == 0) begin
        bus_wr(8'h0C, 32'h76, w);
        wait_evt(300, at, isr);
        chk(at == -1, "R9 stopped stays quiet", at, -1);
        bus_rd(8'h00, d); chk(d == 0, "R9 ctrl reads off", d, 0);
      end
    end

    // R7 / R8 interrupt-first mode
    bus_wr(8'h04, 32'h11, w);
    bus_wr(8'h00, 32'h3, w);
    wait_evt(200, at, isr);
    chk(!isr && at == w + tmo(1), "R7 first expiry irq", at - w, tmo(1));
    chk(irq == 1 && rst_req == 0, "R7 irq without reset", {irq, rst_req}, 2);
    prev = at;
    wait_evt(200, at, isr);
    chk(isr && at == prev + tmo(1), "R7 second expiry resets", at - prev, tmo(1));
    prev = at;
    bus_rd(8'h10, d); chk(d == 1, "R8 status pending", d, 1);
    bus_rd(8'h14, d); chk(d == 1, "R8 ack returns pending", d, 1);
    bus_rd(8'h10, d); chk(d == 0, "R8 status cleared", d, 0);
    chk(irq == 0, "R8 irq cleared", irq, 0);
    wait_evt(200, at, isr);
    chk(!isr && at == prev + tmo(1), "R8 re-armed irq", at - prev, tmo(1));

    // R9 stop mid-count then re-enable from start code
    bus_wr(8'h00, 32'h0, w);
    bus_rd(8'h14, d);
    bus_wr(8'h04, 32'h20, w);
    bus_wr(8'h00, 32'h1, w);
    wait_evt(300, at, isr);
    chk(isr && at == w + tmo(2), "R9 re-enable uses start code", at - w, tmo(2));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule